// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Level Interrupts

This block drives and samples a set of general-purpose I/O lines (32 by default) from a simple register bus with a valid strobe, a write flag, a byte address and a 32-bit data word. Two complete register banks sit side by side. The open bank can always be reached. The guarded bank can only be reached while the access-permit input is high. Each bank holds output, direction, interrupt polarity, interrupt flag and interrupt enable registers, plus read-only input and input-mirror views. A per-line steering register chooses which bank drives a line's output value and output enable, and which bank raises that line's interrupt flag.

Pin inputs pass through a two-flop synchroniser before they reach any register view or interrupt logic. A flag sets while the synchronised input matches the polarity that its bank programs for that line. Software clears a flag by writing a one to it. The condition is sampled again on every clock, so a flag whose condition still holds sets again straight away. Firmware can get edge detection by flipping the polarity bit after each event. The enabled flags of both banks are ORed into one interrupt output. Read data is registered and appears in the cycle after the read strobe.

Top module: `dbgpio_ctrl`

## Requirements
- R1: Byte offsets decode as follows. In the open bank, output is at 0x00, direction at 0x04, input at 0x08, polarity at 0x0C, flag at 0x10, enable at 0x14 and mirror at 0x18. In the guarded bank, the gate register is at 0x1C, output at 0x20, direction at 0x24, input at 0x28, polarity at 0x2C, flag at 0x30, enable at 0x34, mirror at 0x38 and steering at 0x3C. The writable registers read back what was last written, and read data appears one cycle after the read strobe.
- R2: For each line n, pin_o[n] and pin_oe[n] come from bit n of the open bank's output and direction registers when steering bit n is 1. When steering bit n is 0 they come from the guarded bank's registers.
- R3: While acc_permit is 0, reads of offsets 0x1C to 0x3C return zero and writes to them leave every register unchanged. Open-bank accesses are unaffected.
- R4: A flag bit sets while the synchronised input equals the polarity bit: 1 triggers on a high input, 0 on a low input. A pin change can first raise irq_o three clock edges after it is applied. Out of reset, idle low lines owned by the guarded bank therefore raise their guarded flags.
- R5: Writing 1 to a flag bit clears it unless its condition still holds, in which case it stays set. Writing 0 to a flag bit leaves it unchanged.
- R6: irq_o is 1 exactly when some line has both its flag bit and its enable bit set in the same bank.
- R7: A bank's flag bits are held at 0 for lines that the steering register gives to the other bank.
- R8: The input register of each bank returns the synchronised pin values of all lines. The mirror register returns them masked to the lines that bank owns. Writes to either view are ignored.
- R9: After reset, the output, direction, polarity, enable, gate and steering registers are 0 and pin_oe is 0, so every line is an input owned by the guarded bank.
- R10: The gate register at 0x1C is a plain 32-bit read/write register in the guarded bank.
- R11: Addresses at or above 0x40 are unmapped. They read zero, and writes to them change nothing (no aliasing onto 0x00 to 0x3C).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_permit | input | 1 | Grants access to the guarded bank |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | LINES | Write data |
| bus_rdata | output | LINES | Registered read data |
| pin_i | input | LINES | Raw pin inputs |
| pin_o | output | LINES | Pin output values |
| pin_oe | output | LINES | Pin output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the controller with its defaults: 32 lines, an 8-bit byte address and two synchroniser stages. The 8-bit address reaches the unmapped window above 0x3C, and the full-width words exercise steering patterns in which both banks own interleaved lines at once. With two stages, the three-edge latency from a pin change to irq_o can be pinned to an exact cycle, and a clear written while the condition still holds can be seen to leave the flag set.

// File: rtl/gpio_dual_pkg.sv
package gpio_dual_pkg;
  // Local register slot inside one bank; slot order fixes the word offsets.
  typedef enum logic [2:0] {
    LREG_OUT  = 3'd0,
    LREG_DIR  = 3'd1,
    LREG_IN   = 3'd2,
    LREG_LVL  = 3'd3,
    LREG_FLAG = 3'd4,
    LREG_MASK = 3'd5,
    LREG_MIR  = 3'd6
  } lreg_e;

  localparam int unsigned IDX_W      = 4;   // 16 word slots
  localparam int unsigned OPEN_LAST  = 6;
  localparam int unsigned GATE_IDX   = 7;
  localparam int unsigned GUARD_LAST = 14;
  localparam int unsigned STEER_IDX  = 15;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], raw_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_dual_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  lreg_e            wr_sel,
  input  logic [WIDTH-1:0] wdata,
  input  lreg_e            rd_sel,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] own,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lvl_q,
  output logic [WIDTH-1:0] flag_q,
  output logic [WIDTH-1:0] mask_q
);
  logic [WIDTH-1:0] out_d, dir_d, lvl_d, flag_d, mask_d;
  logic [WIDTH-1:0] clr;
  logic [WIDTH-1:0] hit;
  logic             en_out, en_dir, en_lvl, en_mask;

  always_comb begin
    en_out  = wr_en && (wr_sel == LREG_OUT);
    en_dir  = wr_en && (wr_sel == LREG_DIR);
    en_lvl  = wr_en && (wr_sel == LREG_LVL);
    en_mask = wr_en && (wr_sel == LREG_MASK);
    clr     = (wr_en && (wr_sel == LREG_FLAG)) ? wdata : '0;
    out_d   = wdata;
    dir_d   = wdata;
    lvl_d   = wdata;
    mask_d  = wdata;
    // condition: synced input equals programmed polarity, owned lines only
    hit     = own & ~(din ^ lvl_q);
    flag_d  = ((flag_q & ~clr) | hit) & own;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      lvl_q  <= '0;
      mask_q <= '0;
      flag_q <= '0;
    end else begin
      if (en_out)  out_q  <= out_d;
      if (en_dir)  dir_q  <= dir_d;
      if (en_lvl)  lvl_q  <= lvl_d;
      if (en_mask) mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (rd_sel)
      LREG_OUT:  rdata = out_q;
      LREG_DIR:  rdata = dir_q;
      LREG_IN:   rdata = din;
      LREG_LVL:  rdata = lvl_q;
      LREG_FLAG: rdata = flag_q;
      LREG_MASK: rdata = mask_q;
      LREG_MIR:  rdata = din & own;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbgpio_ctrl.sv
module dbgpio_ctrl
  import gpio_dual_pkg::*;
#(
  parameter int unsigned LINES       = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_permit,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pin_i,
  output logic [LINES-1:0]  pin_o,
  output logic [LINES-1:0]  pin_oe,
  output logic              irq_o
);
  localparam int unsigned LO_BITS = 2;
  localparam int unsigned HI_SHIFT = IDX_W + LO_BITS;

  logic              srst_n;
  logic [LINES-1:0]  din;
  logic [IDX_W-1:0]  idx;
  logic              in_map, guarded, allowed;
  logic              wr_fire, rd_fire;
  logic              open_wr, guard_wr, gate_wr, steer_wr;
  lreg_e             slot;

  logic [LINES-1:0]  steer_q, steer_d, gate_q, gate_d;
  logic [LINES-1:0]  open_out, open_dir, open_lvl, open_flag, open_mask, open_rdata;
  logic [LINES-1:0]  guard_out, guard_dir, guard_lvl, guard_flag, guard_mask, guard_rdata;
  logic [LINES-1:0]  rd_mux, rdata_q, rdata_d;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  gpio_in_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .raw_i(pin_i), .sync_o(din)
  );

  // address decode
  always_comb begin
    idx      = bus_addr[HI_SHIFT-1:LO_BITS];
    in_map   = ((bus_addr >> HI_SHIFT) == '0);
    guarded  = (idx >= IDX_W'(GATE_IDX));
    allowed  = in_map && (!guarded || acc_permit);
    slot     = lreg_e'(idx[2:0]);
    wr_fire  = bus_valid && bus_write && allowed;
    rd_fire  = bus_valid && !bus_write;
    open_wr  = wr_fire && (idx <= IDX_W'(OPEN_LAST));
    gate_wr  = wr_fire && (idx == IDX_W'(GATE_IDX));
    guard_wr = wr_fire && (idx > IDX_W'(GATE_IDX)) && (idx <= IDX_W'(GUARD_LAST));
    steer_wr = wr_fire && (idx == IDX_W'(STEER_IDX));
  end

  gpio_bank #(.WIDTH(LINES)) u_open (
    .clk(clk), .rst_n(srst_n),
    .wr_en(open_wr), .wr_sel(slot), .wdata(bus_wdata),
    .rd_sel(slot), .rdata(open_rdata),
    .own(steer_q), .din(din),
    .out_q(open_out), .dir_q(open_dir), .lvl_q(open_lvl),
    .flag_q(open_flag), .mask_q(open_mask)
  );

  gpio_bank #(.WIDTH(LINES)) u_guard (
    .clk(clk), .rst_n(srst_n),
    .wr_en(guard_wr), .wr_sel(slot), .wdata(bus_wdata),
    .rd_sel(slot), .rdata(guard_rdata),
    .own(~steer_q), .din(din),
    .out_q(guard_out), .dir_q(guard_dir), .lvl_q(guard_lvl),
    .flag_q(guard_flag), .mask_q(guard_mask)
  );

  // steering and gate registers
  always_comb begin
    steer_d = bus_wdata;
    gate_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      steer_q <= '0;
      gate_q  <= '0;
    end else begin
      if (steer_wr) steer_q <= steer_d;
      if (gate_wr)  gate_q  <= gate_d;
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    if (allowed) begin
      if (idx <= IDX_W'(OPEN_LAST))       rd_mux = open_rdata;
      else if (idx == IDX_W'(GATE_IDX))   rd_mux = gate_q;
      else if (idx == IDX_W'(STEER_IDX))  rd_mux = steer_q;
      else                                rd_mux = guard_rdata;
    end
    rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      rdata_q <= '0;
    else if (rd_fire) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // pin steering and interrupt combine
  assign pin_o  = (steer_q & open_out) | (~steer_q & guard_out);
  assign pin_oe = (steer_q & open_dir) | (~steer_q & guard_dir);
  assign irq_o  = |((open_flag & open_mask) | (guard_flag & guard_mask));
endmodule

// File: rtl/dbgpio_ctrl_chk.sv
module dbgpio_ctrl_chk #(
  parameter int unsigned LINES  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_permit,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LINES-1:0]  bus_rdata,
  input logic              irq_o,
  input logic [LINES-1:0]  steer_q,
  input logic [LINES-1:0]  open_flag,
  input logic [LINES-1:0]  open_mask,
  input logic [LINES-1:0]  guard_flag,
  input logic [LINES-1:0]  guard_mask,
  input logic [LINES-1:0]  guard_out,
  input logic [LINES-1:0]  guard_dir
);
  logic guard_rd;
  assign guard_rd = bus_valid && !bus_write && ((bus_addr >> 6) == '0) && (bus_addr[5:2] >= 4'd7);

  // R3
  permit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_permit |=> ($stable(guard_out) && $stable(guard_dir) && $stable(steer_q)));

  // R3
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_rd && !acc_permit) |=> (bus_rdata == '0));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($countones((open_flag & open_mask) | (guard_flag & guard_mask)) > 0));

  // R6
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((open_mask == '0) && (guard_mask == '0)) |-> !irq_o);

  // R7
  own_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> ((open_flag & ~$past(steer_q)) == '0));

  // R7
  own_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> ((guard_flag & $past(steer_q)) == '0));
endmodule

bind dbgpio_ctrl dbgpio_ctrl_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dbgpio_ctrl_tb.sv
module dbgpio_ctrl_tb;
  localparam int unsigned LINES  = 32;
  localparam int unsigned ADDR_W = 8;

  localparam logic [7:0] A_OUT = 8'h00, A_DIR = 8'h04, A_IN = 8'h08, A_LVL = 8'h0C,
                         A_FLG = 8'h10, A_MSK = 8'h14, A_MIR = 8'h18, A_GATE = 8'h1C,
                         G_OUT = 8'h20, G_DIR = 8'h24, G_IN = 8'h28, G_LVL = 8'h2C,
                         G_FLG = 8'h30, G_MSK = 8'h34, G_MIR = 8'h38, A_STEER = 8'h3C;

  logic              clk = 1'b0;
  logic              rst_n, acc_permit, bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [LINES-1:0]  bus_wdata, bus_rdata, pin_i, pin_o, pin_oe;
  logic              irq_o;
  int                n_chk = 0;
  int                n_bad = 0;

  always #4 clk = ~clk;

  dbgpio_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_permit(acc_permit),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  task automatic t_reset();
    check("R9 pin_oe", pin_oe, 32'h0);
    check("R9 irq", {31'h0, irq_o}, 32'h0);
    rd_chk("R9 open out", A_OUT, 32'h0);
    rd_chk("R9 open dir", A_DIR, 32'h0);
    rd_chk("R9 guard lvl", G_LVL, 32'h0);
    rd_chk("R9 guard mask", G_MSK, 32'h0);
    rd_chk("R9 steer", A_STEER, 32'h0);
    rd_chk("R9 gate", A_GATE, 32'h0);
    rd_chk("R4 idle low guard flags", G_FLG, 32'hFFFF_FFFF);
  endtask

  task automatic t_steer();
    wr(A_OUT, 32'hA5A5_A5A5);
    wr(A_DIR, 32'hFFFF_0000);
    wr(G_OUT, 32'h0F0F_0F0F);
    wr(G_DIR, 32'h00FF_00FF);
    wr(A_STEER, 32'h1234_5678);
    wr(A_GATE, 32'hDEAD_BEEF);
    rd_chk("R1 open out", A_OUT, 32'hA5A5_A5A5);
    rd_chk("R1 guard dir", G_DIR, 32'h00FF_00FF);
    rd_chk("R1 steer", A_STEER, 32'h1234_5678);
    rd_chk("R10 gate", A_GATE, 32'hDEAD_BEEF);
    check("R2 pin_o", pin_o, (32'h1234_5678 & 32'hA5A5_A5A5) | (~32'h1234_5678 & 32'h0F0F_0F0F));
    check("R2 pin_oe", pin_oe, (32'h1234_5678 & 32'hFFFF_0000) | (~32'h1234_5678 & 32'h00FF_00FF));
  endtask

  task automatic t_permit();
    acc_permit = 1'b0;
    wr(G_OUT, 32'hFFFF_FFFF);
    wr(A_STEER, 32'h0);
    rd_chk("R3 guarded read blocked", G_OUT, 32'h0);
    rd_chk("R3 open read unaffected", A_OUT, 32'hA5A5_A5A5);
    acc_permit = 1'b1;
    rd_chk("R3 guard out kept", G_OUT, 32'h0F0F_0F0F);
    rd_chk("R3 steer kept", A_STEER, 32'h1234_5678);
  endtask

  task automatic t_inputs();
    pin_i = 32'hC3C3_1234;
    repeat (4) @(negedge clk);
    rd_chk("R8 open in", A_IN, 32'hC3C3_1234);
    rd_chk("R8 guard in", G_IN, 32'hC3C3_1234);
    rd_chk("R8 open mirror", A_MIR, 32'hC3C3_1234 & 32'h1234_5678);
    rd_chk("R8 guard mirror", G_MIR, 32'hC3C3_1234 & ~32'h1234_5678);
    wr(A_IN, 32'h0);
    wr(G_MIR, 32'h0);
    rd_chk("R8 open in after write", A_IN, 32'hC3C3_1234);
    rd_chk("R8 guard mirror after write", G_MIR, 32'hC3C3_1234 & ~32'h1234_5678);
  endtask

  task automatic t_irq();
    pin_i = 32'h0;
    wr(A_STEER, 32'h0000_0001);
    wr(A_LVL, 32'h0000_0001);
    wr(A_MSK, 32'h0000_0001);
    repeat (4) @(negedge clk);
    wr(A_FLG, 32'hFFFF_FFFF);
    wr(G_FLG, 32'hFFFF_FFFF);
    check("R6 irq idle", {31'h0, irq_o}, 32'h0);
    rd_chk("R7 guard flags owned only", G_FLG, 32'hFFFF_FFFE);
    // R4 latency: apply at negedge, irq after third edge
    @(negedge clk); pin_i = 32'h0000_0001;
    @(negedge clk); @(negedge clk);
    check("R4 irq not yet", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    check("R4 irq high level", {31'h0, irq_o}, 32'h1);
    wr(A_FLG, 32'h0000_0001);
    rd_chk("R5 clear while held", A_FLG, 32'h1);
    pin_i = 32'h0;
    repeat (4) @(negedge clk);
    wr(A_FLG, 32'h0);
    rd_chk("R5 zero write keeps", A_FLG, 32'h1);
    wr(A_FLG, 32'h0000_0001);
    rd_chk("R5 cleared", A_FLG, 32'h0);
    check("R6 irq after clear", {31'h0, irq_o}, 32'h0);
    wr(A_LVL, 32'h0);
    @(negedge clk);
    rd_chk("R4 low polarity", A_FLG, 32'h1);
    check("R6 irq low polarity", {31'h0, irq_o}, 32'h1);
    wr(A_MSK, 32'h0);
    check("R6 masked off", {31'h0, irq_o}, 32'h0);
    wr(G_MSK, 32'h8000_0000);
    check("R6 guarded line irq", {31'h0, irq_o}, 32'h1);
    wr(G_MSK, 32'h0);
    check("R6 guarded masked", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_unmapped();
    rd_chk("R11 read 0x40", 8'h40, 32'h0);
    rd_chk("R11 read 0xFC", 8'hFC, 32'h0);
    wr(8'h40, 32'h1111_1111);
    rd_chk("R11 no alias", A_OUT, 32'hA5A5_A5A5);
  endtask

  initial begin
    rst_n = 1'b0; acc_permit = 1'b1; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_steer();
    t_permit();
    t_inputs();
    t_irq();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule